// File: doc/BRIEF.md
# Kernel Stack Guard and CPU Error Monitor

This block watches every stack pointer update made in kernel mode and compares the new value with a programmable stack limit. The check uses two bands above the limit. A value in the lower band is a fatal (red) fault: the stack pointer is replaced by a fixed safe value and a red stack trap is posted. A value in the upper band is a warning (yellow): it is recorded and posted, and execution goes on with the value unchanged. Stack updates made in any other mode pass through without a check.

The block also holds the CPU error register, a byte of sticky cause bits. Bus faults, an illegal HALT and a failed trap-vector fetch each set their bit and raise a one-cycle strobe. The trap arbiter that sits next to this block picks up that strobe as the cause to post. Odd-address faults have their own trap cause. Non-existent-memory faults and bus timeouts set different error bits but share one trap cause. A HALT decoded in kernel mode stops the CPU instead. A fault during a vector fetch forces kernel mode and the safe stack value and posts red.

Every result is registered. Strobes and the stack pointer output appear on the clock edge that follows the input cycle.

Top module: `kstk_err_monitor`

## Requirements
- R1: When `mode_i` is not the kernel code (default 0), a stack update is not checked. One cycle later `sp_o` equals the candidate, `sp_force_o`, `post_red_o` and `post_yel_o` are 0, and no error bit changes.
- R2: A kernel-mode stack update whose candidate is below limit + 224 gives, one cycle later, `sp_force_o`=1, `sp_o`=4, `post_red_o`=1 and error bit 2 (0x04) set.
- R3: A kernel-mode update whose candidate is at or above limit + 224 and below limit + 256 gives `post_yel_o`=1 and error bit 3 (0x08), with no force and `sp_o` equal to the candidate. At or above limit + 256 nothing is posted.
- R4: The comparisons are unsigned and use 17 bits, so the bands do not wrap. With limit 0xFFF0, every 16-bit candidate is red.
- R5: A bus fault with kind code 0 (odd address) sets error bit 6 (0x40) and pulses `post_odd_o`.
- R6: Kind code 1 (non-existent memory) sets bit 5 (0x20) and kind code 2 (bus timeout) sets bit 4 (0x10). Both pulse `post_nxm_o`. Kind code 3 has no effect.
- R7: A HALT decoded outside kernel mode sets bit 7 (0x80) and pulses `post_prv_o`. In kernel mode it pulses `cpu_stop_o` and sets no bit.
- R8: A vector-fetch fault pulses `kern_force_o`, `sp_force_o` and `post_red_o`, drives `sp_o`=4 and sets bit 2.
- R9: Error bits are sticky. `err_clr_i` zeroes them all, but a bit set in the same cycle as the clear is kept.
- R10: After reset all outputs are 0. Each strobe is high for exactly one cycle per causing input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | MODE_W | Current processor mode; KERNEL_MODE is kernel |
| sp_upd_i | input | 1 | A stack pointer update is offered this cycle |
| sp_cand_i | input | SP_W | Candidate stack pointer value |
| sp_lim_i | input | SP_W | Stack limit register |
| bus_flt_i | input | 1 | Bus fault strobe |
| bus_flt_kind_i | input | 2 | Fault kind: 0 odd, 1 non-existent, 2 timeout, 3 none |
| vec_flt_i | input | 1 | Bus fault while fetching a trap vector |
| halt_dec_i | input | 1 | HALT instruction decoded |
| err_clr_i | input | 1 | CPU write to the error register (clears it) |
| err_o | output | 8 | Sticky error cause bits |
| sp_vld_o | output | 1 | `sp_o` carries a stack pointer to install |
| sp_force_o | output | 1 | Stack pointer is overridden with the safe value |
| sp_o | output | SP_W | Stack pointer to install |
| kern_force_o | output | 1 | Force kernel mode |
| cpu_stop_o | output | 1 | Stop the CPU (kernel HALT) |
| post_red_o | output | 1 | Post stack-red trap |
| post_yel_o | output | 1 | Post stack-yellow trap |
| post_odd_o | output | 1 | Post odd-address trap |
| post_nxm_o | output | 1 | Post non-existent-memory trap |
| post_prv_o | output | 1 | Post privileged-instruction trap |

## Verification
Two things can land in the same cycle. First, a stack update can be judged red or yellow in the cycle that a bus fault, a vector-fetch fault, an illegal HALT or a register clear also arrives. Second, a new error bit can be set in the very cycle that the register is cleared. The random phase drives all of these inputs on their own each cycle, with a bias toward candidates inside the two bands and occasional clears. Directed cases then fire a red stack update together with a timeout and a clear. A bench model forms the expected strobes and the merged error byte, with the set winning over the clear, and compares them with the registered outputs one edge later.

// File: rtl/kstk_pkg.sv
// Package: shared encodings for the kernel stack guard and error monitor.
// Holds the bus-fault kind codes, the error-register bit positions and the
// bundle of trap-post strobes. Bit positions are fixed because software and
// the trap arbiter decode them.
package kstk_pkg;

    localparam int ERR_W = 8;

    // Bit positions inside the error register
    localparam int EB_RED = 2;
    localparam int EB_YEL = 3;
    localparam int EB_TMO = 4;
    localparam int EB_NXM = 5;
    localparam int EB_ODD = 6;
    localparam int EB_HLT = 7;

    // Bus fault kind codes
    typedef enum logic [1:0] {
        FK_ODD  = 2'd0,
        FK_NXM  = 2'd1,
        FK_TMO  = 2'd2,
        FK_NONE = 2'd3
    } fault_kind_e;

    // Trap causes raised toward the arbiter
    typedef struct packed {
        logic red;
        logic yel;
        logic odd;
        logic nxm;
        logic prv;
    } post_t;

endpackage

// File: rtl/kstk_window_chk.sv
// Module: kstk_window_chk
// Classifies a candidate stack pointer against two bands that sit a fixed
// distance above the limit. Purely combinational. Assumes the caller gates
// chk_en with "stack update in kernel mode". Sums are carried one bit wider
// than the pointer, so a limit near the top of the range cannot wrap.
module kstk_window_chk #(
    parameter int SP_W    = 16,
    parameter int RED_OFS = 224,
    parameter int YEL_OFS = 256
) (
    input  logic            chk_en,
    input  logic [SP_W-1:0] sp_cand,
    input  logic [SP_W-1:0] sp_lim,
    output logic            is_red,
    output logic            is_yel
);
    localparam int XW = SP_W + 1;

    logic [XW-1:0] red_top;
    logic [XW-1:0] yel_top;
    logic [XW-1:0] sp_x;

    // Widen the operands and form both band tops without wrap
    always_comb begin
        sp_x    = {1'b0, sp_cand};
        red_top = {1'b0, sp_lim} + XW'(RED_OFS);
        yel_top = {1'b0, sp_lim} + XW'(YEL_OFS);
    end

    // Red takes precedence; yellow only when the pointer is above the red band
    always_comb begin
        is_red = chk_en && (sp_x < red_top);
        is_yel = chk_en && !is_red && (sp_x < yel_top);
    end

endmodule

// File: rtl/kstk_fault_map.sv
// Module: kstk_fault_map
// Maps the stack verdict, bus faults, vector-fetch faults and the decoded
// HALT onto error-register set bits and trap-post strobes. Combinational.
// Odd-address faults have their own trap cause. Non-existent memory and
// timeout have separate error bits but share one trap cause.
module kstk_fault_map
    import kstk_pkg::*;
(
    input  logic             is_red,
    input  logic             is_yel,
    input  logic             bus_flt,
    input  logic [1:0]       bus_flt_kind,
    input  logic             vec_flt,
    input  logic             halt_dec,
    input  logic             in_kernel,
    output logic [ERR_W-1:0] set_bits,
    output post_t            post,
    output logic             stop_req
);
    fault_kind_e kind;
    logic        f_odd;
    logic        f_nxm;
    logic        f_tmo;

    // Decode the bus fault kind into one flag per cause
    always_comb begin
        kind  = fault_kind_e'(bus_flt_kind);
        f_odd = 1'b0;
        f_nxm = 1'b0;
        f_tmo = 1'b0;
        if (bus_flt) begin
            case (kind)
                FK_ODD:  f_odd = 1'b1;
                FK_NXM:  f_nxm = 1'b1;
                FK_TMO:  f_tmo = 1'b1;
                default: ;
            endcase
        end
    end

    // Assemble the error bits that this cycle sets
    always_comb begin
        set_bits         = '0;
        set_bits[EB_RED] = is_red || vec_flt;
        set_bits[EB_YEL] = is_yel;
        set_bits[EB_TMO] = f_tmo;
        set_bits[EB_NXM] = f_nxm;
        set_bits[EB_ODD] = f_odd;
        set_bits[EB_HLT] = halt_dec && !in_kernel;
    end

    // Trap causes to post and the CPU stop request
    always_comb begin
        post.red = is_red || vec_flt;
        post.yel = is_yel;
        post.odd = f_odd;
        post.nxm = f_nxm || f_tmo;
        post.prv = halt_dec && !in_kernel;
        stop_req = halt_dec && in_kernel;
    end

endmodule

// File: rtl/kstk_err_reg.sv
// Module: kstk_err_reg
// Sticky error cause register. Each bit is set by its cause and cleared only
// by reset or by a CPU write. A set arriving together with a clear wins,
// so a fault in that cycle is not lost. Each bit is its own flop, built
// with a generate loop.
module kstk_err_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_bits,
    output logic [W-1:0] err_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold, clear or set one cause bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_q[i] <= 1'b0;
            else if (set_bits[i])
                err_q[i] <= 1'b1;
            else if (clr)
                err_q[i] <= 1'b0;
        end

        AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !clr) |=> err_q[i]); // R9
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (set_bits == '0)) |=> (err_q == '0)); // R9

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((err_q & $past(set_bits)) == $past(set_bits))); // R9

endmodule

// File: rtl/kstk_err_monitor.sv
// Module: kstk_err_monitor (top)
// Kernel stack limit guard and CPU error monitor. Checks kernel-mode stack
// updates against the limit bands, keeps the sticky error register, and
// registers the forced stack pointer and the trap-post strobes. All outputs
// appear one clock after the inputs that cause them. Assumes every input
// strobe is one cycle wide and synchronous to clk.
module kstk_err_monitor
    import kstk_pkg::*;
#(
    parameter int SP_W        = 16,
    parameter int MODE_W      = 2,
    parameter int KERNEL_MODE = 0,
    parameter int RED_OFS     = 224,
    parameter int YEL_OFS     = 256,
    parameter int FORCED_SP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sp_upd_i,
    input  logic [SP_W-1:0]   sp_cand_i,
    input  logic [SP_W-1:0]   sp_lim_i,
    input  logic              bus_flt_i,
    input  logic [1:0]        bus_flt_kind_i,
    input  logic              vec_flt_i,
    input  logic              halt_dec_i,
    input  logic              err_clr_i,
    output logic [ERR_W-1:0]  err_o,
    output logic              sp_vld_o,
    output logic              sp_force_o,
    output logic [SP_W-1:0]   sp_o,
    output logic              kern_force_o,
    output logic              cpu_stop_o,
    output logic              post_red_o,
    output logic              post_yel_o,
    output logic              post_odd_o,
    output logic              post_nxm_o,
    output logic              post_prv_o
);
    localparam logic [MODE_W-1:0] KMODE = MODE_W'(KERNEL_MODE);
    localparam logic [SP_W-1:0]   SAFE  = SP_W'(FORCED_SP);
    localparam int                XW    = SP_W + 1;

    logic             in_kernel;
    logic             chk_en;
    logic             is_red;
    logic             is_yel;
    logic [ERR_W-1:0] set_bits;
    post_t            post_d;
    post_t            post_q;
    logic             stop_d;
    logic             force_d;
    logic [SP_W-1:0]  sp_d;

    // Qualify the stack check by mode
    always_comb begin
        in_kernel = (mode_i == KMODE);
        chk_en    = sp_upd_i && in_kernel;
    end

    kstk_window_chk #(
        .SP_W    (SP_W),
        .RED_OFS (RED_OFS),
        .YEL_OFS (YEL_OFS)
    ) u_win (
        .chk_en  (chk_en),
        .sp_cand (sp_cand_i),
        .sp_lim  (sp_lim_i),
        .is_red  (is_red),
        .is_yel  (is_yel)
    );

    kstk_fault_map u_map (
        .is_red       (is_red),
        .is_yel       (is_yel),
        .bus_flt      (bus_flt_i),
        .bus_flt_kind (bus_flt_kind_i),
        .vec_flt      (vec_flt_i),
        .halt_dec     (halt_dec_i),
        .in_kernel    (in_kernel),
        .set_bits     (set_bits),
        .post         (post_d),
        .stop_req     (stop_d)
    );

    kstk_err_reg #(
        .W (ERR_W)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (err_clr_i),
        .set_bits (set_bits),
        .err_q    (err_o)
    );

    // Choose the stack pointer to install: safe value on a fatal fault
    always_comb begin
        force_d = is_red || vec_flt_i;
        sp_d    = force_d ? SAFE : sp_cand_i;
    end

    // Register the stack pointer path and all strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_vld_o     <= 1'b0;
            sp_force_o   <= 1'b0;
            sp_o         <= '0;
            kern_force_o <= 1'b0;
            cpu_stop_o   <= 1'b0;
            post_q       <= '0;
        end else begin
            sp_vld_o     <= sp_upd_i || vec_flt_i;
            sp_force_o   <= force_d;
            sp_o         <= sp_d;
            kern_force_o <= vec_flt_i;
            cpu_stop_o   <= stop_d;
            post_q       <= post_d;
        end
    end

    // Unpack the registered trap strobes onto the ports
    always_comb begin
        post_red_o = post_q.red;
        post_yel_o = post_q.yel;
        post_odd_o = post_q.odd;
        post_nxm_o = post_q.nxm;
        post_prv_o = post_q.prv;
    end

    AST_USER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_upd_i && (mode_i != KMODE) && !vec_flt_i) |=>
        (!sp_force_o && (sp_o == $past(sp_cand_i)) && !post_red_o && !post_yel_o)); // R1

    AST_RED_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_upd_i && (mode_i == KMODE) && ({1'b0, sp_cand_i} < ({1'b0, sp_lim_i} + XW'(RED_OFS)))) |=>
        (sp_force_o && (sp_o == SAFE) && post_red_o && err_o[EB_RED])); // R2

    AST_YEL_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (post_yel_o && !kern_force_o) |-> !sp_force_o); // R3

    AST_ODD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_flt_i && (bus_flt_kind_i == 2'd0)) |=> (post_odd_o && err_o[EB_ODD])); // R5

    AST_NXM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_flt_i && ((bus_flt_kind_i == 2'd1) || (bus_flt_kind_i == 2'd2))) |=> post_nxm_o); // R6

    AST_HALT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_dec_i && (mode_i != KMODE)) |=> (post_prv_o && err_o[EB_HLT] && !cpu_stop_o)); // R7

    AST_VEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_flt_i |=> (kern_force_o && sp_force_o && (sp_o == SAFE) && post_red_o)); // R8

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_dec_i && !vec_flt_i) |=> (!cpu_stop_o && !kern_force_o)); // R10

endmodule

// File: tb/kstk_err_monitor_tb.sv
// Bench for kstk_err_monitor: seeded random stimulus plus directed corners,
// compared with a bench model one clock edge after each input cycle.
module kstk_err_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        sp_upd;
    logic [15:0] sp_cand;
    logic [15:0] sp_lim;
    logic        bus_flt;
    logic [1:0]  flt_kind;
    logic        vec_flt;
    logic        halt_dec;
    logic        err_clr;

    logic [7:0]  err_o;
    logic        sp_vld_o, sp_force_o, kern_force_o, cpu_stop_o;
    logic [15:0] sp_o;
    logic        post_red_o, post_yel_o, post_odd_o, post_nxm_o, post_prv_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_err;

    always #10 clk = ~clk;   // 50 MHz

    kstk_err_monitor u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode),
        .sp_upd_i       (sp_upd),
        .sp_cand_i      (sp_cand),
        .sp_lim_i       (sp_lim),
        .bus_flt_i      (bus_flt),
        .bus_flt_kind_i (flt_kind),
        .vec_flt_i      (vec_flt),
        .halt_dec_i     (halt_dec),
        .err_clr_i      (err_clr),
        .err_o          (err_o),
        .sp_vld_o       (sp_vld_o),
        .sp_force_o     (sp_force_o),
        .sp_o           (sp_o),
        .kern_force_o   (kern_force_o),
        .cpu_stop_o     (cpu_stop_o),
        .post_red_o     (post_red_o),
        .post_yel_o     (post_yel_o),
        .post_odd_o     (post_odd_o),
        .post_nxm_o     (post_nxm_o),
        .post_prv_o     (post_prv_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Error bits that the current inputs set
    function automatic logic [7:0] model_set();
        logic [16:0] sx, rt, yt;
        logic kern, red, yel;
        logic [7:0] s;
        sx   = {1'b0, sp_cand};
        rt   = {1'b0, sp_lim} + 17'd224;
        yt   = {1'b0, sp_lim} + 17'd256;
        kern = (mode == 2'd0);
        red  = sp_upd && kern && (sx < rt);
        yel  = sp_upd && kern && !red && (sx < yt);
        s    = 8'h00;
        s[2] = red || vec_flt;
        s[3] = yel;
        s[4] = bus_flt && (flt_kind == 2'd2);
        s[5] = bus_flt && (flt_kind == 2'd1);
        s[6] = bus_flt && (flt_kind == 2'd0);
        s[7] = halt_dec && !kern;
        return s;
    endfunction

    // Expected registered strobes and pointer {vld,force,kern,stop,red,yel,odd,nxm,prv,sp}
    function automatic logic [24:0] model_out();
        logic [7:0] s;
        logic frc;
        s   = model_set();
        frc = s[2];
        return {sp_upd || vec_flt, frc, vec_flt, halt_dec && (mode == 2'd0),
                s[2], s[3], s[6], s[4] || s[5], s[7],
                frc ? 16'd4 : sp_cand};
    endfunction

    function automatic logic [24:0] dut_out();
        return {sp_vld_o, sp_force_o, kern_force_o, cpu_stop_o,
                post_red_o, post_yel_o, post_odd_o, post_nxm_o, post_prv_o, sp_o};
    endfunction

    task automatic idle();
        sp_upd = 0; bus_flt = 0; flt_kind = 2'd3; vec_flt = 0;
        halt_dec = 0; err_clr = 0;
    endtask

    // Apply the current inputs for one edge and compare with the model
    task automatic cycle(input string tag);
        logic [24:0] eo;
        logic [7:0]  ee;
        eo = model_out();
        ee = (err_clr ? 8'h00 : m_err) | model_set();
        @(posedge clk); #2;
        m_err = ee;
        chk({tag, " outputs"}, 64'(dut_out()), 64'(eo));
        chk({tag, " err"}, 64'(err_o), 64'(ee));
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        rst_n = 0; mode = 2'd0; sp_cand = 16'h0; sp_lim = 16'h0; idle();
        m_err = 8'h00;
        repeat (3) @(posedge clk); #2;
        chk("R10 reset outputs", 64'(dut_out()), 64'd0);
        chk("R10 reset err", 64'(err_o), 64'd0);
        @(negedge clk); rst_n = 1;

        // R1: user mode, very low pointer, no check
        mode = 2'd3; sp_lim = 16'h0100; sp_cand = 16'h0000; sp_upd = 1;
        cycle("R1 user pass");
        chk("R1 err untouched", 64'(err_o), 64'h00);

        // R2: just inside the red band
        mode = 2'd0; sp_cand = 16'h01DF; sp_upd = 1;
        cycle("R2 red edge");
        chk("R2 forced sp", 64'(sp_o), 64'h4);
        chk("R2 err red bit", 64'(err_o), 64'h04);
        err_clr = 1; cycle("R9 clear");
        chk("R9 cleared", 64'(err_o), 64'h00);

        // R3: band edges
        sp_cand = 16'h01E0; sp_upd = 1; cycle("R3 yellow low edge");
        chk("R3 yellow bit", 64'(err_o), 64'h08);
        sp_cand = 16'h01FF; sp_upd = 1; cycle("R3 yellow top edge");
        chk("R3 no force", 64'(sp_force_o), 64'h0);
        err_clr = 1; cycle("R9 clear2");
        sp_cand = 16'h0200; sp_upd = 1; cycle("R3 clear of bands");
        chk("R3 nothing posted", 64'({post_red_o, post_yel_o}), 64'h0);
        chk("R3 no bit", 64'(err_o), 64'h00);

        // R4: limit near top, no wrap
        sp_lim = 16'hFFF0; sp_cand = 16'hFFFF; sp_upd = 1; cycle("R4 no wrap");
        chk("R4 red at top", 64'(post_red_o), 64'h1);
        err_clr = 1; cycle("R9 clear3");

        // R5 / R6: bus faults
        bus_flt = 1; flt_kind = 2'd0; cycle("R5 odd");
        chk("R5 odd bit", 64'(err_o), 64'h40);
        bus_flt = 1; flt_kind = 2'd1; cycle("R6 nxm");
        chk("R6 nxm post", 64'(post_nxm_o), 64'h1);
        bus_flt = 1; flt_kind = 2'd2; cycle("R6 timeout");
        chk("R6 timeout bits", 64'(err_o), 64'h70);
        err_clr = 1; bus_flt = 1; flt_kind = 2'd3; cycle("R6 kind3 ignored");
        chk("R6 kind3 no bit", 64'(err_o), 64'h00);
        chk("R6 kind3 no post", 64'({post_odd_o, post_nxm_o}), 64'h0);

        // R7: HALT
        mode = 2'd3; halt_dec = 1; cycle("R7 user halt");
        chk("R7 halt bit", 64'(err_o), 64'h80);
        mode = 2'd0; halt_dec = 1; cycle("R7 kernel halt");
        chk("R7 stop", 64'(cpu_stop_o), 64'h1);
        err_clr = 1; cycle("R9 clear4");

        // R8: vector fetch fault in user mode
        mode = 2'd3; vec_flt = 1; sp_cand = 16'h1234; cycle("R8 vector fault");
        chk("R8 kernel forced", 64'({kern_force_o, sp_o}), 64'h1_0004);

        // R9: clear with simultaneous red stack and timeout
        mode = 2'd0; sp_lim = 16'h0300; sp_cand = 16'h0310; sp_upd = 1;
        bus_flt = 1; flt_kind = 2'd2; err_clr = 1;
        cycle("R9 set beats clear");
        chk("R9 merged bits", 64'(err_o), 64'h14);
        cycle("R10 strobes drop");
        chk("R10 single pulse", 64'({post_red_o, post_nxm_o, sp_force_o}), 64'h0);

        // Random phase: all inputs independent, biased toward the bands
        for (int n = 0; n < 3000; n++) begin
            mode     = ($urandom_range(0, 3) == 0) ? 2'(($urandom_range(1, 3))) : 2'd0;
            sp_lim   = 16'($urandom());
            sp_cand  = ($urandom_range(0, 3) == 0) ? 16'($urandom())
                                                   : 16'(sp_lim + 16'($urandom_range(0, 300)));
            sp_upd   = ($urandom_range(0, 1) == 1);
            bus_flt  = ($urandom_range(0, 3) == 0);
            flt_kind = 2'($urandom_range(0, 3));
            vec_flt  = ($urandom_range(0, 15) == 0);
            halt_dec = ($urandom_range(0, 7) == 0);
            err_clr  = ($urandom_range(0, 5) == 0);
            cycle("random R1 R2 R3 R4 R5 R6 R7 R8 R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule